// File: doc/BRIEF.md
# Hyperframe Control Pointer Manager

This block looks after the single control byte in each radio-interface hyperframe that says where the fast control-and-management (Ethernet) channel begins. It works on a stream of control words. Each word comes with its index inside the hyperframe, and a strobe marks the first word of each new hyperframe.

On the transmit side, the block passes the outgoing byte stream through with one register stage. At the pointer position it replaces the byte with the pointer value that software has configured.

On the receive side, it takes the byte at the same position and runs it through a persistence filter. The accepted pointer only moves to a new value after that value has arrived in four hyperframes in a row. Software can also load the accepted pointer directly, for example during link setup. The accepted pointer is then classified:
- Zero means no Ethernet channel.
- Values in the usable subchannel window mean the channel is present.
- Any other non-zero value is flagged as invalid. This includes the reserved subchannels below the window.

Top module: `hf_ptr_mgr`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `rx_ptr` is 0x00, `tx_byte` is 0x00, and both `eth_present` and `ptr_invalid` are low.
- R2: A cycle with `cw_valid` high and `cw_idx` equal to `PTR_IDX` (default 194) is a slot cycle. After a slot cycle, `tx_byte` equals the `tx_ptr_cfg` value sampled in that cycle, one clock later.
- R3: In every other cycle, `tx_byte` takes the value of `tx_data_in`, one clock later. This includes cycles at index `PTR_IDX` with `cw_valid` low.
- R4: A received pointer value becomes `rx_ptr` only in the cycle after the `MATCH_N`-th (default 4) consecutive hyperframe that carries it. Before that, `rx_ptr` keeps its old value.
- R5: A hyperframe whose pointer differs from the current candidate makes it the new candidate, with a run length of one. The values from earlier in the broken run no longer count.
- R6: Only the first slot cycle after a `hf_sync` pulse counts toward the run. Further slot cycles before the next `hf_sync` are ignored. A `hf_sync` cycle may itself be a slot cycle.
- R7: `sw_load` writes `sw_ptr` into `rx_ptr` on the next clock. It wins over a slot cycle in the same cycle, and it clears the run, so the next received value starts a new run of one.
- R8: `eth_present` is high exactly when `rx_ptr` lies within 0x24..0x3F inclusive. It changes in the same cycle as `rx_ptr`.
- R9: `ptr_invalid` is high exactly when `rx_ptr` is non-zero and outside 0x24..0x3F. This covers the reserved subchannels 0x10..0x23. A value of 0x00 leaves both flags low.
- R10: Bytes received in cycles that are not slot cycles have no effect on the run or on `rx_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hf_sync | input | 1 | Marks the first control word of a hyperframe |
| cw_valid | input | 1 | A control word is present this cycle |
| cw_idx | input | 8 | Index of the control word within the hyperframe |
| rx_byte | input | 8 | Received control byte |
| tx_data_in | input | 8 | Outgoing control byte before insertion |
| tx_ptr_cfg | input | 8 | Configured transmit pointer |
| sw_load | input | 1 | Load `sw_ptr` into the accepted pointer |
| sw_ptr | input | 8 | Pointer value loaded by software |
| tx_byte | output | 8 | Outgoing control byte after insertion |
| rx_ptr | output | 8 | Accepted receive pointer |
| eth_present | output | 1 | Accepted pointer is in the usable window |
| ptr_invalid | output | 1 | Accepted pointer is non-zero and not usable |

## Verification
The classifier is swept over all 256 pointer values by loading each one through `sw_load`. Those values are compared with the window bounds worked out arithmetically, which separates the zero code, the reserved codes, the usable window and the codes above it.

The transmit path is swept over all 256 configured values in slot cycles. It is also swept with a distinct payload in non-slot cycles, which tells insertion apart from pass-through.

The receive filter gets several sequences, each checked after every hyperframe:
- Clean runs of four.
- Runs broken one short of acceptance.
- Repeated slot bytes inside one hyperframe.
- Stray bytes at neighbouring indices and with `cw_valid` low.
- A software load landing on the cycle that would complete a run.

Together these separate a correct counter from one that accepts early or late, fails to restart, or listens to the wrong bytes.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int PTR_W = 8;

  typedef enum logic [1:0] {
    PC_NONE = 2'd0,
    PC_ETH  = 2'd1,
    PC_BAD  = 2'd2
  } ptr_class_e;

  function automatic ptr_class_e classify(input logic [PTR_W-1:0] v,
                                          input logic [PTR_W-1:0] lo,
                                          input logic [PTR_W-1:0] hi);
    if (v == '0)                 return PC_NONE;
    else if (v >= lo && v <= hi) return PC_ETH;
    else                         return PC_BAD;
  endfunction
endpackage

// File: rtl/hfp_slot_detect.sv
module hfp_slot_detect #(
  parameter int IDX_W   = 8,
  parameter int PTR_IDX = 194
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hf_sync,
  input  logic             cw_valid,
  input  logic [IDX_W-1:0] cw_idx,
  output logic             slot_hit,
  output logic             slot_cap
);
  logic taken;

  assign slot_hit = cw_valid && (cw_idx == IDX_W'(PTR_IDX));
  // first slot after a boundary only; the boundary cycle itself may hold it
  assign slot_cap = slot_hit && (hf_sync || !taken);

  always_ff @(posedge clk) begin
    if (rst)          taken <= 1'b0;
    else if (hf_sync) taken <= slot_cap;
    else if (slot_cap) taken <= 1'b1;
  end
endmodule

// File: rtl/hfp_tx_insert.sv
module hfp_tx_insert #(
  parameter int D_W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slot_hit,
  input  logic [D_W-1:0] tx_data_in,
  input  logic [D_W-1:0] tx_ptr_cfg,
  output logic [D_W-1:0] tx_byte
);
  always_ff @(posedge clk) begin
    if (rst)           tx_byte <= '0;
    else if (slot_hit) tx_byte <= tx_ptr_cfg;
    else               tx_byte <= tx_data_in;
  end
endmodule

// File: rtl/hfp_rx_filter.sv
module hfp_rx_filter #(
  parameter int D_W     = 8,
  parameter int MATCH_N = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           slot_cap,
  input  logic [D_W-1:0] rx_byte,
  input  logic           sw_load,
  input  logic [D_W-1:0] sw_ptr,
  output logic [D_W-1:0] acc,
  output logic [D_W-1:0] acc_nxt
);
  localparam int CNT_W = $clog2(MATCH_N + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MATCH_N);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [D_W-1:0]   cand, cand_nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  always_comb begin
    acc_nxt  = acc;
    cand_nxt = cand;
    cnt_nxt  = cnt;
    if (sw_load) begin
      acc_nxt  = sw_ptr;
      cand_nxt = sw_ptr;
      cnt_nxt  = '0;
    end else if (slot_cap) begin
      if (cnt != '0 && rx_byte == cand) begin
        if (cnt != CNT_MAX) cnt_nxt = cnt + CNT_ONE;
        if (cnt == CNT_MAX - CNT_ONE) acc_nxt = rx_byte;
      end else begin
        cand_nxt = rx_byte;
        cnt_nxt  = CNT_ONE;
        if (CNT_ONE == CNT_MAX) acc_nxt = rx_byte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc  <= '0;
      cand <= '0;
      cnt  <= '0;
    end else begin
      acc  <= acc_nxt;
      cand <= cand_nxt;
      cnt  <= cnt_nxt;
    end
  end
endmodule

// File: rtl/hfp_classify.sv
module hfp_classify
  import hfp_pkg::*;
#(
  parameter logic [PTR_W-1:0] WIN_LO = 8'h24,
  parameter logic [PTR_W-1:0] WIN_HI = 8'h3F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] ptr_nxt,
  output logic             eth_present,
  output logic             ptr_invalid
);
  ptr_class_e cls;

  assign cls = classify(ptr_nxt, WIN_LO, WIN_HI);

  always_ff @(posedge clk) begin
    if (rst) begin
      eth_present <= 1'b0;
      ptr_invalid <= 1'b0;
    end else begin
      eth_present <= (cls == PC_ETH);
      ptr_invalid <= (cls == PC_BAD);
    end
  end
endmodule

// File: rtl/hf_ptr_mgr.sv
module hf_ptr_mgr
  import hfp_pkg::*;
#(
  parameter int IDX_W   = 8,
  parameter int PTR_IDX = 194,
  parameter int MATCH_N = 4,
  parameter logic [PTR_W-1:0] WIN_LO = 8'h24,
  parameter logic [PTR_W-1:0] WIN_HI = 8'h3F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hf_sync,
  input  logic             cw_valid,
  input  logic [IDX_W-1:0] cw_idx,
  input  logic [PTR_W-1:0] rx_byte,
  input  logic [PTR_W-1:0] tx_data_in,
  input  logic [PTR_W-1:0] tx_ptr_cfg,
  input  logic             sw_load,
  input  logic [PTR_W-1:0] sw_ptr,
  output logic [PTR_W-1:0] tx_byte,
  output logic [PTR_W-1:0] rx_ptr,
  output logic             eth_present,
  output logic             ptr_invalid
);
  logic             slot_hit, slot_cap;
  logic [PTR_W-1:0] ptr_nxt;

  hfp_slot_detect #(.IDX_W(IDX_W), .PTR_IDX(PTR_IDX)) u_slot (
    .clk(clk), .rst(rst), .hf_sync(hf_sync), .cw_valid(cw_valid),
    .cw_idx(cw_idx), .slot_hit(slot_hit), .slot_cap(slot_cap)
  );

  hfp_tx_insert #(.D_W(PTR_W)) u_tx (
    .clk(clk), .rst(rst), .slot_hit(slot_hit), .tx_data_in(tx_data_in),
    .tx_ptr_cfg(tx_ptr_cfg), .tx_byte(tx_byte)
  );

  hfp_rx_filter #(.D_W(PTR_W), .MATCH_N(MATCH_N)) u_rx (
    .clk(clk), .rst(rst), .slot_cap(slot_cap), .rx_byte(rx_byte),
    .sw_load(sw_load), .sw_ptr(sw_ptr), .acc(rx_ptr), .acc_nxt(ptr_nxt)
  );

  hfp_classify #(.WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_cls (
    .clk(clk), .rst(rst), .ptr_nxt(ptr_nxt),
    .eth_present(eth_present), .ptr_invalid(ptr_invalid)
  );
endmodule

// File: rtl/hfp_checker.sv
module hfp_checker #(
  parameter int IDX_W   = 8,
  parameter int PTR_IDX = 194,
  parameter logic [7:0] WIN_LO = 8'h24,
  parameter logic [7:0] WIN_HI = 8'h3F
) (
  input logic             clk,
  input logic             rst,
  input logic             cw_valid,
  input logic [IDX_W-1:0] cw_idx,
  input logic [7:0]       tx_data_in,
  input logic [7:0]       tx_ptr_cfg,
  input logic             sw_load,
  input logic [7:0]       sw_ptr,
  input logic [7:0]       tx_byte,
  input logic [7:0]       rx_ptr,
  input logic             eth_present,
  input logic             ptr_invalid
);
  logic hit_in;
  assign hit_in = cw_valid && (cw_idx == IDX_W'(PTR_IDX));

  a_r2_insert: assert property (@(posedge clk) disable iff (rst)
    $past(hit_in) |-> tx_byte == $past(tx_ptr_cfg));

  a_r3_passthru: assert property (@(posedge clk) disable iff (rst)
    !$past(hit_in) |-> tx_byte == $past(tx_data_in));

  a_r4_change_cause: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_ptr) |-> ($past(sw_load) || $past(hit_in)));

  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    $past(sw_load) |-> rx_ptr == $past(sw_ptr));

  a_r8_present: assert property (@(posedge clk) disable iff (rst)
    eth_present == (rx_ptr >= WIN_LO && rx_ptr <= WIN_HI));

  a_r9_invalid: assert property (@(posedge clk) disable iff (rst)
    ptr_invalid == (rx_ptr != 8'h00 && (rx_ptr < WIN_LO || rx_ptr > WIN_HI)));
endmodule

bind hf_ptr_mgr hfp_checker #(
  .IDX_W(IDX_W), .PTR_IDX(PTR_IDX), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
) u_chk (
  .clk(clk), .rst(rst), .cw_valid(cw_valid), .cw_idx(cw_idx),
  .tx_data_in(tx_data_in), .tx_ptr_cfg(tx_ptr_cfg), .sw_load(sw_load),
  .sw_ptr(sw_ptr), .tx_byte(tx_byte), .rx_ptr(rx_ptr),
  .eth_present(eth_present), .ptr_invalid(ptr_invalid)
);

// File: tb/hf_ptr_mgr_test.sv
`timescale 1ns/1ps
module hf_ptr_mgr_test;
  localparam int SLOT = 194;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hf_sync = 1'b0, cw_valid = 1'b0, sw_load = 1'b0;
  logic [7:0] cw_idx = '0, rx_byte = '0, tx_data_in = '0, tx_ptr_cfg = '0, sw_ptr = '0;
  logic [7:0] tx_byte, rx_ptr;
  logic       eth_present, ptr_invalid;

  int  n_run = 0, n_fail = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  hf_ptr_mgr uut (
    .clk(clk), .rst(rst), .hf_sync(hf_sync), .cw_valid(cw_valid),
    .cw_idx(cw_idx), .rx_byte(rx_byte), .tx_data_in(tx_data_in),
    .tx_ptr_cfg(tx_ptr_cfg), .sw_load(sw_load), .sw_ptr(sw_ptr),
    .tx_byte(tx_byte), .rx_ptr(rx_ptr), .eth_present(eth_present),
    .ptr_invalid(ptr_invalid)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [7:0] v);
    return (v >= 8'h24 && v <= 8'h3F);
  endfunction

  // one clock: drive at negedge, sample just after posedge
  task automatic cyc(input logic sync, input logic vld, input logic [7:0] idx,
                     input logic [7:0] rxb, input logic ld = 1'b0,
                     input logic [7:0] swp = 8'h00);
    @(negedge clk);
    hf_sync = sync; cw_valid = vld; cw_idx = idx; rx_byte = rxb;
    sw_load = ld; sw_ptr = swp;
    @(posedge clk); #1;
  endtask

  task automatic frame(input logic [7:0] v);
    cyc(1'b1, 1'b1, 8'd0, 8'h00);
    cyc(1'b0, 1'b1, 8'(SLOT), v);
  endtask

  task automatic chk_ptr(input string req, input logic [7:0] exp);
    check(req, rx_ptr, exp);
    check(req, {7'd0, eth_present}, {7'd0, in_win(exp)});
    check(req, {7'd0, ptr_invalid}, {7'd0, exp != 8'h00 && !in_win(exp)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk_ptr("R1", 8'h00);
    check("R1", tx_byte, 8'h00);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    chk_ptr("R1", 8'h00);
    check("R1", tx_byte, 8'h00);

    // R8/R9/R7 sweep via software load
    for (int v = 0; v < 256; v++) begin
      cyc(1'b0, 1'b0, 8'd0, 8'h00, 1'b1, 8'(v));
      chk_ptr("R7_R8_R9", 8'(v));
    end

    // R2/R3 sweep on the transmit path
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); tx_ptr_cfg = 8'(v); tx_data_in = 8'(v) ^ 8'hA5;
      cyc(1'b0, 1'b1, 8'(SLOT), 8'h00);
      check("R2", tx_byte, 8'(v));
      cyc(1'b0, 1'b1, 8'(v == SLOT ? 0 : v), 8'h00);
      check("R3", tx_byte, 8'(v) ^ 8'hA5);
      cyc(1'b0, 1'b0, 8'(SLOT), 8'h00);
      check("R3", tx_byte, 8'(v) ^ 8'hA5);
    end

    // R4: clean run of four
    cyc(1'b0, 1'b0, 8'd0, 8'h00, 1'b1, 8'h00);
    for (int i = 0; i < 3; i++) begin
      frame(8'h30);
      chk_ptr("R4", 8'h00);
    end
    frame(8'h30);
    chk_ptr("R4", 8'h30);

    // R5: run broken one short, then restarted
    frame(8'h28); frame(8'h28); frame(8'h28);
    frame(8'h29);
    chk_ptr("R5", 8'h30);
    frame(8'h28); frame(8'h28); frame(8'h28);
    chk_ptr("R5", 8'h30);
    frame(8'h28);
    chk_ptr("R5", 8'h28);

    // R6: second slot in the same hyperframe is ignored
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b1, 8'd0, 8'h00);
      cyc(1'b0, 1'b1, 8'(SLOT), 8'h2A);
      cyc(1'b0, 1'b1, 8'(SLOT), 8'h35);
    end
    chk_ptr("R6", 8'h2A);
    // R6: hf_sync cycle that is itself a slot cycle
    for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 8'(SLOT), 8'h3E);
    chk_ptr("R6", 8'h3E);

    // R10: stray bytes at other indices and with cw_valid low
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, 1'b1, 8'd0, 8'h3C);
      cyc(1'b0, 1'b1, 8'(SLOT - 1), 8'h3C);
      cyc(1'b0, 1'b1, 8'(SLOT), 8'h31);
      cyc(1'b0, 1'b0, 8'(SLOT), 8'h3C);
      cyc(1'b0, 1'b1, 8'(SLOT + 1), 8'h3C);
    end
    chk_ptr("R10", 8'h31);

    // R7: load wins over the completing slot and clears the run
    frame(8'h26); frame(8'h26); frame(8'h26);
    cyc(1'b1, 1'b1, 8'd0, 8'h00);
    cyc(1'b0, 1'b1, 8'(SLOT), 8'h26, 1'b1, 8'h05);
    chk_ptr("R7", 8'h05);
    frame(8'h26); frame(8'h26); frame(8'h26);
    chk_ptr("R7", 8'h05);
    frame(8'h26);
    chk_ptr("R7", 8'h26);

    // R9: reserved subchannel accepted from the line is flagged
    for (int i = 0; i < 4; i++) frame(8'h12);
    chk_ptr("R9", 8'h12);

    // R1: reset mid-run returns to the reset state
    frame(8'h2C);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk_ptr("R1", 8'h00);
    check("R1", tx_byte, 8'h00);
    @(negedge clk); rst = 1'b0;

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule